// File: doc/BRIEF.md
# SPI Slave Serializer with Transmit Holding Register

This block is the target side of a four-wire serial link. An external controller drives the select, serial clock and data-in lines. The block shifts one frame of 8 to 16 bits while select is low and drives its reply on the data-out line. All serial inputs are sampled by a faster system clock and pass through two-flop synchronizers before edge detection. Clock idle level and capture edge are set by configuration inputs. These inputs are expected to stay constant while select is low.

Software-side logic writes transmit words through a one-deep holding register. There is no queue, so a newer write replaces an older one that has not been sent. At the end of each frame the holding word moves into the shift register. If nothing new was written, the word just received stays in the shift register and goes out again in the next frame, and an underrun is flagged. Each received frame goes to a receive register. A ready flag marks it as unread, and an overrun flag shows that an unread word was overwritten. Separate read strobes acknowledge the receive word and the status flags.

Top module: `spi_slave_hold`

## Requirements
- R1: While `nss` is high, `sck` edges have no effect: no bit is counted, `rxReady` does not rise and the word sent in the next frame is unchanged.
- R2: `cfgBits` is a binary bit count. Values from 8 to 16 are used as given, values below 8 act as 8 and values above 16 act as 16. Words are right-aligned in `wrData` and `rxData`, and upper bits of `rxData` read as zero.
- R3: `cfgCpol` is the idle level of `sck`, so the leading edge is rising when it is 0 and falling when it is 1. When `cfgLeadCapture` is 1, `mosi` is sampled on the leading edge. When it is 0, `mosi` is sampled on the trailing edge. In both cases `miso` advances to the next bit after each trailing edge.
- R4: `miso` carries the frame most significant bit first, and the first bit is valid from the start of select. `mosi` is shifted in most significant bit first.
- R5: When the last bit of a frame has been shifted, `rxData` takes the received word and `rxReady` goes to 1. A one-cycle `rdRx` pulse clears `rxReady`.
- R6: If a frame completes while `rxReady` is still 1, `overrun` goes to 1 and `rxData` is still replaced by the new word.
- R7: After reset the shift register is all zeros, `miso` is 0, `rxData` is 0, `txEmpty` is 1, and `rxReady`, `overrun` and `underrun` are 0. A frame sent before any write or receive transmits all zeros.
- R8: The first `wrEn` write after reset goes straight into the shift register and leaves `txEmpty` at 1, so the next frame sends that word.
- R9: Every later write goes to the holding register and clears `txEmpty`, and a newer write replaces a pending older one. At the end of the next frame the pending word is loaded into the shift register and `txEmpty` returns to 1.
- R10: If no word is pending when a frame ends, the received word (zero-extended) stays in the shift register for the next frame and `underrun` goes to 1.
- R11: A one-cycle `rdStat` pulse clears `overrun` and `underrun` on the next clock edge. A frame end in the same cycle takes priority and sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgBits | input | 5 | Bits per frame, clamped to 8..16 |
| cfgCpol | input | 1 | Serial clock idle level |
| cfgLeadCapture | input | 1 | 1: sample `mosi` on the leading edge, 0: on the trailing edge |
| nss | input | 1 | Active-low select from the controller |
| sck | input | 1 | Serial clock from the controller |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| wrEn | input | 1 | Transmit word write strobe |
| wrData | input | 16 | Transmit word, right-aligned |
| rdRx | input | 1 | Receive word read strobe, clears `rxReady` |
| rdStat | input | 1 | Status read strobe, clears `overrun` and `underrun` |
| rxData | output | 16 | Last received word, right-aligned |
| rxReady | output | 1 | Unread received word present |
| txEmpty | output | 1 | Holding register free for a new word |
| overrun | output | 1 | A received word was replaced before being read |
| underrun | output | 1 | A frame ended with no new transmit word pending |

## Verification
The assertions assume that the frame configuration does not change while select is low. They also assume that `sck` holds each level for at least two system clocks, so that every edge is detected exactly once. The bench changes configuration only while select is high, with the clock already at its new idle level, and holds each serial clock phase for four system clocks. Transmit writes are issued only between frames. This keeps the direct first-write path and the holding path clearly separate from frame boundaries.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

  // Strobes from control to datapath, one system clock each.
  typedef struct packed {
    logic directLoad;  // write goes straight into the shift register
    logic holdWrite;   // write goes into the holding register
    logic sampleTake;  // latch mosi on a capture-only edge
    logic shiftStep;   // shift one bit in and advance miso
    logic frameEnd;    // this shift completes the frame
    logic reload;      // at frame end, take the holding word
    logic useSample;   // shift in the latched bit, not live mosi
  } dpStrobes_t;

endpackage

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
  parameter int NUM = 3,
  parameter logic [NUM-1:0] RST_VAL = '0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NUM-1:0] rawIn,
  output logic [NUM-1:0] syncOut,
  output logic [NUM-1:0] prevOut
);

  for (genvar g = 0; g < NUM; g++) begin : gChain
    logic meta, stable, last;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta   <= RST_VAL[g];
        stable <= RST_VAL[g];
        last   <= RST_VAL[g];
      end else begin
        meta   <= rawIn[g];
        stable <= meta;
        last   <= stable;
      end
    end
    assign syncOut[g] = stable;
    assign prevOut[g] = last;
  end

endmodule

// File: rtl/spi_slave_ctrl.sv
module spi_slave_ctrl
  import spi_slave_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MIN_BITS = 8,
  localparam int CNT_W   = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nssActive,
  input  logic             leadEdge,
  input  logic             trailEdge,
  input  logic [CNT_W-1:0] cfgBits,
  input  logic             cfgLeadCapture,
  input  logic             wrEn,
  input  logic             rdRx,
  input  logic             rdStat,
  output dpStrobes_t       strobes,
  output logic [CNT_W-1:0] nBits,
  output logic             rxReady,
  output logic             txEmpty,
  output logic             overrun,
  output logic             underrun
);

  logic [CNT_W-1:0] bitCnt;
  logic pending, firstDone;
  logic shiftStep, lastBit, busy, directLoad, holdWrite, frameEnd;

  always_comb begin
    if (cfgBits < CNT_W'(MIN_BITS))     nBits = CNT_W'(MIN_BITS);
    else if (cfgBits > CNT_W'(DATA_W))  nBits = CNT_W'(DATA_W);
    else                                nBits = cfgBits;
  end

  always_comb begin
    shiftStep  = nssActive & trailEdge;
    lastBit    = (bitCnt == nBits - CNT_W'(1));
    busy       = (bitCnt != '0);
    frameEnd   = shiftStep & lastBit;
    directLoad = wrEn & ~firstDone & ~busy & ~shiftStep;
    holdWrite  = wrEn & ~directLoad;
    strobes.directLoad = directLoad;
    strobes.holdWrite  = holdWrite;
    strobes.sampleTake = nssActive & leadEdge;
    strobes.shiftStep  = shiftStep;
    strobes.frameEnd   = frameEnd;
    strobes.reload     = pending;
    strobes.useSample  = cfgLeadCapture;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      pending   <= 1'b0;
      firstDone <= 1'b0;
      rxReady   <= 1'b0;
      txEmpty   <= 1'b1;
      overrun   <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      if (!nssActive)      bitCnt <= '0;
      else if (shiftStep)  bitCnt <= lastBit ? '0 : bitCnt + CNT_W'(1);

      if (wrEn) firstDone <= 1'b1;

      if (frameEnd)        pending <= holdWrite;
      else if (holdWrite)  pending <= 1'b1;

      if (holdWrite)                 txEmpty <= 1'b0;
      else if (frameEnd && pending)  txEmpty <= 1'b1;

      if (frameEnd)   rxReady <= 1'b1;
      else if (rdRx)  rxReady <= 1'b0;

      if (frameEnd && rxReady)  overrun <= 1'b1;
      else if (rdStat)          overrun <= 1'b0;

      if (frameEnd && !pending) underrun <= 1'b1;
      else if (rdStat)          underrun <= 1'b0;
    end
  end

  assert_idle_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    !nssActive |=> !$rose(rxReady));
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (nssActive && $stable(nBits)) |-> (bitCnt < nBits));
  assert_rx_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> rxReady);
  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && rxReady) |=> overrun);
  assert_first_direct_R8: assert property (@(posedge clk) disable iff (!rstN)
    directLoad |=> (txEmpty && !pending));
  assert_tx_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && pending && !wrEn) |=> txEmpty);
  assert_underrun_R10: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !pending) |=> underrun);
  assert_stat_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdStat && !frameEnd) |=> (!overrun && !underrun));

endmodule

// File: rtl/spi_slave_dp.sv
module spi_slave_dp
  import spi_slave_pkg::*;
#(
  parameter int DATA_W  = 16,
  localparam int CNT_W  = $clog2(DATA_W + 1),
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [CNT_W-1:0]  nBits,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mosiSync,
  output logic              miso,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] shiftReg, holdReg, frameMask, shifted;
  logic [IDX_W-1:0]  outIdx;
  logic sampleBit, inBit;

  always_comb begin
    frameMask = ~({DATA_W{1'b1}} << nBits);
    inBit     = strobes.useSample ? sampleBit : mosiSync;
    shifted   = {shiftReg[DATA_W-2:0], inBit};
    outIdx    = IDX_W'(nBits - CNT_W'(1));
    miso      = shiftReg[outIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      holdReg   <= '0;
      rxData    <= '0;
      sampleBit <= 1'b0;
    end else begin
      if (strobes.sampleTake) sampleBit <= mosiSync;
      if (strobes.holdWrite)  holdReg   <= wrData;
      if (strobes.directLoad) begin
        shiftReg <= wrData;
      end else if (strobes.shiftStep) begin
        if (strobes.frameEnd) begin
          rxData   <= shifted & frameMask;
          shiftReg <= strobes.reload ? holdReg : (shifted & frameMask);
        end else begin
          shiftReg <= shifted;
        end
      end
    end
  end

  assert_reload_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.frameEnd && strobes.reload) |=> (shiftReg == $past(holdReg)));
  assert_retransmit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.frameEnd && !strobes.reload) |=> (shiftReg == rxData));
  assert_rx_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frameEnd |=> ((rxData & ~$past(frameMask)) == '0));

endmodule

// File: rtl/spi_slave_hold.sv
module spi_slave_hold
  import spi_slave_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MIN_BITS = 8,
  localparam int CNT_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cfgBits,
  input  logic              cfgCpol,
  input  logic              cfgLeadCapture,
  input  logic              nss,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdRx,
  input  logic              rdStat,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              txEmpty,
  output logic              overrun,
  output logic              underrun
);

  // bit 2: select, bit 1: serial clock, bit 0: data in
  logic [2:0] syncNow, syncLast;
  logic sckRise, sckFall, leadEdge, trailEdge, nssActive;
  dpStrobes_t strobes;
  logic [CNT_W-1:0] nBits;

  spi_slave_sync #(.NUM(3), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rstN(rstN), .rawIn({nss, sck, mosi}),
    .syncOut(syncNow), .prevOut(syncLast)
  );

  always_comb begin
    sckRise   = syncNow[1] & ~syncLast[1];
    sckFall   = ~syncNow[1] & syncLast[1];
    leadEdge  = cfgCpol ? sckFall : sckRise;
    trailEdge = cfgCpol ? sckRise : sckFall;
    nssActive = ~syncNow[2];
  end

  spi_slave_ctrl #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .nssActive(nssActive), .leadEdge(leadEdge),
    .trailEdge(trailEdge), .cfgBits(cfgBits), .cfgLeadCapture(cfgLeadCapture),
    .wrEn(wrEn), .rdRx(rdRx), .rdStat(rdStat), .strobes(strobes),
    .nBits(nBits), .rxReady(rxReady), .txEmpty(txEmpty),
    .overrun(overrun), .underrun(underrun)
  );

  spi_slave_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .nBits(nBits),
    .wrData(wrData), .mosiSync(syncNow[0]), .miso(miso), .rxData(rxData)
  );

endmodule

// File: tb/test_spi_slave_hold.sv
module test_spi_slave_hold;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic [4:0] cfgBits = 5'd8;
  logic cfgCpol = 1'b0, cfgLeadCapture = 1'b1;
  logic nss = 1'b1, sck = 1'b0, mosi = 1'b0, miso;
  logic wrEn = 1'b0, rdRx = 1'b0, rdStat = 1'b0;
  logic [15:0] wrData = '0, rxData;
  logic rxReady, txEmpty, overrun, underrun;

  int tests = 0, failed = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] mShift = '0, mHold = '0, mRx = '0;
  bit mFirst = 0, mPending = 0, mRxReady = 0, mOverrun = 0, mUnderrun = 0, mTxEmpty = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slave_hold i_spi_slave_hold (
    .clk(clk), .rstN(rstN), .cfgBits(cfgBits), .cfgCpol(cfgCpol),
    .cfgLeadCapture(cfgLeadCapture), .nss(nss), .sck(sck), .mosi(mosi),
    .miso(miso), .wrEn(wrEn), .wrData(wrData), .rdRx(rdRx), .rdStat(rdStat),
    .rxData(rxData), .rxReady(rxReady), .txEmpty(txEmpty),
    .overrun(overrun), .underrun(underrun)
  );

  function automatic int effBits(int raw);
    return raw < 8 ? 8 : (raw > 16 ? 16 : raw);
  endfunction

  function automatic logic [15:0] maskOf(int n);
    return 16'((32'h1 << n) - 1);
  endfunction

  task automatic tick(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkFlags(string req);
    check({req, " rxReady"}, 32'(rxReady), 32'(mRxReady));
    check({req, " txEmpty"}, 32'(txEmpty), 32'(mTxEmpty));
    check({req, " overrun"}, 32'(overrun), 32'(mOverrun));
    check({req, " underrun"}, 32'(underrun), 32'(mUnderrun));
    check({req, " rxData"}, 32'(rxData), 32'(mRx));
  endtask

  task automatic writeWord(logic [15:0] d);
    wrEn = 1'b1; wrData = d; tick(1);
    wrEn = 1'b0; tick(2);
    if (!mFirst) begin mShift = d; mFirst = 1; end
    else begin mHold = d; mPending = 1; mTxEmpty = 0; end
  endtask

  task automatic readRx();
    rdRx = 1'b1; tick(1); rdRx = 1'b0; tick(1);
    mRxReady = 0;
  endtask

  task automatic readStat();
    rdStat = 1'b1; tick(1); rdStat = 1'b0; tick(1);
    mOverrun = 0; mUnderrun = 0;
  endtask

  task automatic setMode(bit pol, bit lead, int raw);
    cfgCpol = pol; cfgLeadCapture = lead; cfgBits = 5'(raw);
    sck = pol; tick(6);
  endtask

  // one frame as controller; checks the reply and the flags afterwards
  task automatic runFrame(logic [15:0] mw, string req);
    int n = effBits(int'(cfgBits));
    logic [15:0] msk = maskOf(n);
    logic [15:0] expSent = mShift & msk;
    logic [15:0] got = '0;
    nss = 1'b0; tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      if (cfgLeadCapture) begin
        mosi = mw[i]; tick(HALF);
        got[i] = miso;
        sck = ~cfgCpol; tick(HALF);
        sck = cfgCpol;
      end else begin
        sck = ~cfgCpol; mosi = mw[i]; tick(HALF);
        got[i] = miso;
        sck = cfgCpol; tick(HALF);
      end
    end
    tick(HALF + 2);
    nss = 1'b1; tick(4);
    check({req, " R4 miso word"}, 32'(got), 32'(expSent));
    if (mRxReady) mOverrun = 1;
    mRxReady = 1;
    mRx = mw & msk;
    if (mPending) begin mShift = mHold; mPending = 0; mTxEmpty = 1; end
    else begin mShift = mw & msk; mUnderrun = 1; end
    checkFlags({req, " R5"});
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    tick(3);
    rstN = 1'b1;
    tick(3);

    // R7: reset state
    checkFlags("R7 reset");
    check("R7 miso at reset", 32'(miso), 0);

    // R7: frame before any write sends zeros; R10 underrun
    setMode(0, 1, 8);
    runFrame(16'h00A5, "R7 zero frame");
    check("R10 underrun after empty frame", 32'(underrun), 1);
    readRx(); readStat();
    checkFlags("R11 R5 after reads");

    // R8: first write direct
    writeWord(16'h003C);
    check("R8 txEmpty stays", 32'(txEmpty), 1);
    runFrame(16'h0011, "R8 first word");
    readRx(); readStat();

    // R9: replacement in holding register; R10 retransmit of last received
    writeWord(16'h0077);
    writeWord(16'h00C3);
    check("R9 txEmpty cleared", 32'(txEmpty), 0);
    runFrame(16'h0022, "R10 retransmit");
    check("R9 txEmpty after load", 32'(txEmpty), 1);
    readRx();
    runFrame(16'h0033, "R9 newest word sent");
    readRx(); readStat();

    // R1: clock toggles with select high are ignored
    for (int k = 0; k < 10; k++) begin
      sck = ~sck; mosi = k[0]; tick(HALF);
    end
    sck = cfgCpol; tick(4);
    check("R1 no rxReady while deselected", 32'(rxReady), 0);
    checkFlags("R1 flags unchanged");
    runFrame(16'h0044, "R1 next frame intact");

    // R6: overrun without reading
    runFrame(16'h0055, "R6 overrun frame");
    check("R6 overrun set", 32'(overrun), 1);
    check("R6 rxData replaced", 32'(rxData), 32'h55);
    readStat();
    check("R11 overrun cleared", 32'(overrun), 0);
    readRx();

    // R2: clamping
    setMode(0, 1, 4);
    writeWord(16'h00F0);
    runFrame(16'hFF96, "R2 clamp low");
    check("R2 rxData 8 bits", 32'(rxData), 32'h96);
    readRx(); readStat();
    setMode(0, 1, 31);
    writeWord(16'hBEEF);
    runFrame(16'h1234, "R2 clamp high");
    runFrame(16'hCAFE, "R2 sixteen bits");
    readRx(); readStat();

    // R3: all clock modes at 12 bits
    for (int m = 0; m < 4; m++) begin
      setMode(m[1], m[0], 12);
      writeWord(16'(12'h5A0 + m));
      runFrame(16'(12'hA51 ^ (m * 16'h111)), "R3 mode");
      runFrame(16'(12'h3C7 + m), "R3 mode retransmit");
      readRx(); readStat();
    end

    // random traffic
    for (int it = 0; it < 40; it++) begin
      int nw;
      setMode($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(6, 18));
      nw = $urandom_range(0, 2);
      for (int w = 0; w < nw; w++) writeWord(16'($urandom));
      runFrame(16'($urandom), "R4 random");
      if ($urandom_range(0, 2) != 0) readRx();
      if ($urandom_range(0, 1) != 0) readStat();
      checkFlags("R11 random reads");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule